// File: doc/BRIEF.md
# Gated-Reload Watchdog Timer

This block supervises a processor. A fixed-ratio divider turns the system clock into a machine-cycle strobe, one for every twelve clocks. A prescaler then divides that strobe by 2^PRE_W and clocks an 8-bit up-counter. When the counter rolls over from its top value, the block issues a one-clock system reset request. It also starts a reset-output pulse that lasts a fixed number of machine cycles.

To keep the system alive, software must reload the counter before it rolls over. A reload is a two-step ritual. A control write first sets an arm flag. Only then does a counter write take effect, and that write clears the arm flag again. A stray or runaway write therefore cannot keep the watchdog fed.

A board-level pin selects one of two modes:

- **Pin low:** the watchdog runs, and requests for power-down are refused.
- **Pin high:** the watchdog is frozen at zero, and power-down requests are honoured.

The bus writes are single-cycle strobes that are always accepted, so there is no valid/ready handshake and no back-pressure. All other pins are plain control and status signals.

Top module: `wdog_gated`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `rst_req`, `rst_pulse` and `pd_state` are 0. The counter, the prescaler and the arm flag are cleared.
- R2: Assume the pin is low, the counter starts from 0 after reset, and there are no writes. Then `rst_req` is high in exactly the cycle after the 256·2^PRE_W-th machine-cycle strobe.
- R3: Assume the arm flag is set and a counter write carries value N in `wr_data[7:0]`. The counter loads N and the prescaler clears. `rst_req` then follows the (256−N)·2^PRE_W-th machine-cycle strobe after the load.
- R4: A counter write made while the arm flag is clear is ignored, and the timeout keeps running from its previous state.
- R5: The arm flag clears in the cycle a reload is accepted. A second counter write made without re-arming is ignored.
- R6: `rst_req` is high for exactly one clock. `rst_pulse` rises in the same cycle and stays high for PULSE_MC machine cycles.
- R7: While `wd_off_pin` is high:
  - the counter and prescaler are held at 0;
  - counter writes are ignored;
  - no `rst_req` is produced.

  After the pin falls, the full 256-tick timeout starts from zero.
- R8: A control write with bit 1 set raises `pd_state` on the next cycle only while `wd_off_pin` is high. While the pin is low, such a write is ignored. A low pin clears `pd_state` on the next cycle.
- R9: `cpu_idle` has no effect, and the timeout length is the same with it high.
- R10: With EXT_TICK=1, `mc_tick_in` is used as the machine-cycle strobe in place of the internal divide-by-12. With a strobe on alternate clocks, the timeout doubles.
- R11: An overflow wraps the counter to 0 and clears the arm flag. Without a reload, the next overflow follows a full 256 ticks later. An unarmed write after the overflow is ignored.
- R12: A control write loads the arm flag from `wr_data[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| mc_tick_in | input | 1 | External machine-cycle strobe, used when EXT_TICK=1 |
| cnt_wr | input | 1 | Write strobe for the counter reload |
| ctl_wr | input | 1 | Write strobe for the control register (bit 0 arm, bit 1 power-down) |
| wr_data | input | DW | Write data shared by both strobes |
| wd_off_pin | input | 1 | High: watchdog off, power-down allowed; low: watchdog on |
| cpu_idle | input | 1 | Processor idle status, with no effect on the watchdog |
| rst_req | output | 1 | One-clock internal reset request on overflow |
| rst_pulse | output | 1 | Reset-output pulse, PULSE_MC machine cycles wide |
| pd_state | output | 1 | Power-down state |

## Verification
The bench predicts the exact clock of each overflow.

- **Timing errors.** A prescaler that is not cleared on reload, or a counter that loads one tick late, shifts the overflow by up to 2^PRE_W machine cycles. The prediction catches this.
- **Gating errors.** The bench issues an unarmed write, a second write without re-arming, and a write after an overflow. A design that leaves the arm flag set would accept these and move the overflow.
- **Pin and pulse errors.** Power-down requests are made under both pin levels, and the bench checks that the counter stays frozen while the pin is high. Pulse-width checks detect a pulse counter that is off by one machine cycle.
- **Strobe-source errors.** A run with the strobe on alternate clocks shows whether the counter wrongly follows the raw clock.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // control-register field positions
  localparam int CTL_ARM_BIT = 0;
  localparam int CTL_PD_BIT  = 1;
endpackage

// File: rtl/wdog_mc_tick.sv
module wdog_mc_tick #(
  parameter bit EXT_TICK = 1'b0,
  parameter int DIV      = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_tick,
  output logic mc_tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [DW-1:0] div_q;
  logic          div_tick;

  assign div_tick = (div_q == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)        div_q <= '0;
    else if (div_tick) div_q <= '0;
    else               div_q <= div_q + DW'(1);
  end

  // parameter picks the strobe source (R10)
  assign mc_tick = EXT_TICK ? ext_tick : div_tick;
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int PRE_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  input  logic mc_tick,
  output logic t3_tick
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              pre_q <= '0;
    else if (!run || clear)  pre_q <= '0;
    else if (mc_tick)        pre_q <= pre_q + PRE_W'(1);
  end

  assign t3_tick = run && !clear && mc_tick && (pre_q == '1);

  a_r7_pre_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_q == '0));
  a_r3_pre_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (pre_q == '0));
endmodule

// File: rtl/wdog_t3.sv
module wdog_t3
  import wdog_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          t3_tick,
  input  logic          cnt_wr,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wr_data,
  output logic          load_ok,
  output logic          ovf
);
  logic [CNT_W-1:0] cnt_q;
  logic             arm_q;

  assign load_ok = cnt_wr && arm_q && run;
  assign ovf     = t3_tick && (cnt_q == '1) && !load_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                arm_q <= 1'b0;
    else if (load_ok || ovf)   arm_q <= 1'b0;
    else if (ctl_wr)           arm_q <= wr_data[CTL_ARM_BIT];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (load_ok)  cnt_q <= wr_data[CNT_W-1:0];
    else if (t3_tick)  cnt_q <= cnt_q + CNT_W'(1);
  end

  a_r5_arm_autoclear: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> !arm_q);
  a_r4_unarmed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_wr && !arm_q) |=> ((cnt_q == $past(cnt_q)) ||
                            (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))) ||
                            (cnt_q == '0)));
  a_r11_ovf_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ((cnt_q == '0) && !arm_q));
  a_r7_cnt_held: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int PULSE_MC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  input  logic mc_tick,
  output logic rst_req,
  output logic rst_pulse
);
  localparam int PW = $clog2(PULSE_MC + 1);

  logic [PW-1:0] pcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                         pcnt_q <= '0;
    else if (ovf)                       pcnt_q <= PW'(PULSE_MC);
    else if (mc_tick && pcnt_q != '0)   pcnt_q <= pcnt_q - PW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rst_req <= 1'b0;
    else        rst_req <= ovf;
  end

  assign rst_pulse = (pcnt_q != '0);

  a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  a_r6_pulse_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_pulse) |-> rst_req);
endmodule

// File: rtl/wdog_gated.sv
module wdog_gated
  import wdog_pkg::*;
#(
  parameter bit EXT_TICK = 1'b0,
  parameter int MC_DIV   = 12,
  parameter int PRE_W    = 11,
  parameter int CNT_W    = 8,
  parameter int DW       = 8,
  parameter int PULSE_MC = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mc_tick_in,
  input  logic          cnt_wr,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wr_data,
  input  logic          wd_off_pin,
  input  logic          cpu_idle,
  output logic          rst_req,
  output logic          rst_pulse,
  output logic          pd_state
);
  logic run, mc_tick, t3_tick, load_ok, ovf, pd_q;

  assign run = !wd_off_pin;

  wdog_mc_tick #(.EXT_TICK(EXT_TICK), .DIV(MC_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .ext_tick(mc_tick_in), .mc_tick(mc_tick));

  wdog_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(load_ok),
    .mc_tick(mc_tick), .t3_tick(t3_tick));

  wdog_t3 #(.CNT_W(CNT_W), .DW(DW)) u_t3 (
    .clk(clk), .rst_n(rst_n), .run(run), .t3_tick(t3_tick),
    .cnt_wr(cnt_wr), .ctl_wr(ctl_wr), .wr_data(wr_data),
    .load_ok(load_ok), .ovf(ovf));

  wdog_rst_pulse #(.PULSE_MC(PULSE_MC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .ovf(ovf), .mc_tick(mc_tick),
    .rst_req(rst_req), .rst_pulse(rst_pulse));

  // power-down accepted only while the watchdog is held off
  always_ff @(posedge clk) begin
    if (!rst_n)                              pd_q <= 1'b0;
    else if (run)                            pd_q <= 1'b0;
    else if (ctl_wr && wr_data[CTL_PD_BIT])  pd_q <= 1'b1;
  end

  assign pd_state = pd_q;

  a_r8_pd_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> !pd_state);
  a_r7_no_req_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_off_pin && $past(wd_off_pin)) |-> !rst_req);
  a_r9_idle_keeps_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_idle && ovf) |=> rst_req);
endmodule

// File: tb/wdog_gated_bench.sv
module wdog_gated_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_W = 3;
  localparam int M     = 1 << PRE_W;
  localparam int TOUT  = 256 * M;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mc_tick_in = 1'b1;
  logic       cnt_wr = 1'b0, ctl_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wd_off_pin = 1'b0, cpu_idle = 1'b0;
  logic       rst_req, rst_pulse, pd_state;

  int checks = 0, fails = 0, seen = 0, cyc = 0, c0 = 0, e = 0;
  bit tog_mode = 1'b0;
  int exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (tog_mode) mc_tick_in <= ~mc_tick_in;

  wdog_gated #(.EXT_TICK(1'b1), .PRE_W(PRE_W), .PULSE_MC(3)) u_wdog_gated (
    .clk(clk), .rst_n(rst_n), .mc_tick_in(mc_tick_in), .cnt_wr(cnt_wr),
    .ctl_wr(ctl_wr), .wr_data(wr_data), .wd_off_pin(wd_off_pin),
    .cpu_idle(cpu_idle), .rst_req(rst_req), .rst_pulse(rst_pulse),
    .pd_state(pd_state));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pop expected overflow cycle and compare
  always @(negedge clk) begin
    if (rst_req === 1'b1) begin
      if (exp_q.size() == 0) chk("R2 unexpected rst_req", cyc, -1);
      else chk("R2/R3 overflow cycle", cyc, exp_q.pop_front());
      seen++;
    end
  end

  task automatic do_reset(bit pin);
    @(negedge clk);
    rst_n = 1'b0; cnt_wr = 0; ctl_wr = 0; wd_off_pin = pin;
    tog_mode = 0; mc_tick_in = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    c0 = cyc;
  endtask

  task automatic wr_ctl(logic [7:0] d);
    ctl_wr = 1; wr_data = d; @(negedge clk); ctl_wr = 0;
  endtask

  // drives a counter write; e = cycle count of the edge that samples it
  task automatic wr_cnt(logic [7:0] d);
    cnt_wr = 1; wr_data = d; e = cyc + 1; @(negedge clk); cnt_wr = 0;
  endtask

  task automatic wait_seen(int n, string req);
    int g = 0;
    while (seen < n && g < 3 * TOUT) begin @(negedge clk); g++; end
    chk(req, seen, n);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 rst_req", rst_req, 0);
    chk("R1 rst_pulse", rst_pulse, 0);
    chk("R1 pd_state", pd_state, 0);

    // R2, R6, R11: free-running timeout, pulse, wrap and arm cleared by overflow
    do_reset(0);
    @(negedge clk);
    chk("R1 outputs after release", {rst_req, rst_pulse, pd_state}, 0);
    exp_q.push_back(c0 + TOUT);
    exp_q.push_back(c0 + 2 * TOUT);
    wr_ctl(8'h01);                       // R12 arm, then left unused
    while (rst_req !== 1'b1) @(negedge clk);
    chk("R6 pulse starts with req", rst_pulse, 1);
    @(negedge clk);
    chk("R6 req one clock", rst_req, 0);
    chk("R6 pulse cycle 2", rst_pulse, 1);
    @(negedge clk);
    chk("R6 pulse cycle 3", rst_pulse, 1);
    wr_cnt(8'd200);                      // R11 arm cleared by overflow: ignored
    chk("R6 pulse ends", rst_pulse, 0);
    wait_seen(2, "R11 second overflow");

    // R4: unarmed write ignored
    seen = 0; do_reset(0);
    exp_q.push_back(c0 + TOUT);
    wr_cnt(8'd200);
    wait_seen(1, "R4 unarmed write ignored");

    // R3, R12: armed reload
    seen = 0; do_reset(0);
    repeat (13) @(negedge clk);
    wr_ctl(8'h01);
    wr_cnt(8'd200);
    exp_q.push_back(e + (256 - 200) * M);
    wait_seen(1, "R3 armed reload");

    // R5: auto-clear, second write ignored
    seen = 0; do_reset(0);
    wr_ctl(8'h01);
    wr_cnt(8'd128);
    exp_q.push_back(e + 128 * M);
    wr_cnt(8'd250);
    wait_seen(1, "R5 second write ignored");

    // R3: re-arm and reload again
    seen = 0; do_reset(0);
    wr_ctl(8'h01); wr_cnt(8'd128);
    repeat (100) @(negedge clk);
    wr_ctl(8'h01); wr_cnt(8'd250);
    exp_q.push_back(e + 6 * M);
    wait_seen(1, "R3 re-armed reload");

    // R9: idle has no effect
    seen = 0; do_reset(0);
    cpu_idle = 1'b1;
    exp_q.push_back(c0 + TOUT);
    wait_seen(1, "R9 idle timeout");
    cpu_idle = 1'b0;

    // R10: strobe on alternate clocks
    seen = 0; do_reset(0);
    exp_q.push_back(c0 + 2 * TOUT - 1);
    @(posedge clk); tog_mode = 1'b1;
    wait_seen(1, "R10 external strobe");
    tog_mode = 1'b0;

    // R7, R8: pin high
    seen = 0; do_reset(1);
    wr_ctl(8'h03);
    chk("R8 pd honoured when pin high", pd_state, 1);
    wr_cnt(8'd250);
    repeat (TOUT + 500) @(negedge clk);
    chk("R7 no overflow while off", seen, 0);
    chk("R7 no pulse while off", rst_pulse, 0);
    wd_off_pin = 1'b0;
    c0 = cyc;
    @(negedge clk);
    chk("R8 pd cleared by pin low", pd_state, 0);
    exp_q.push_back(c0 + TOUT);
    wait_seen(1, "R7 full timeout after pin falls");

    // R8: pd request ignored with pin low
    seen = 0; do_reset(0);
    wr_ctl(8'h02);
    chk("R8 pd ignored when pin low", pd_state, 0);

    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule